// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block collects interrupt requests from peripheral sources into a 16-bit latched status register and gates them with a 16-bit enable mask. Each source line is a one-cycle set pulse for its own status bit. A bus master clears requests with an AND-style acknowledge. The value written to the status location is ANDed into the stored bits, so a 0 clears a bit and a 1 keeps it. Writing the mask location loads the whole mask.

A single registered pending output goes to the processor's cause logic. It is high whenever any latched request is also enabled. It is recomputed at the same clock edge that changes either register, whether the change comes from a set pulse, an acknowledge or a mask load. When a mask load enables a request that is already latched, the block also raises a one-cycle event pulse. The processor side uses this pulse to re-check for interrupts at once. Source 3 is by convention the DMA controller; the logic treats every source the same way.

Top module: `irqc_top`

## Requirements
- R1: A write to the status word (byte offset 0x070, address bits [1:0] ignored) stores the old status ANDed with write data bits [15:0]: a written 0 clears a bit, a written 1 leaves it unchanged.
- R2: A write to the mask word (byte offset 0x074) replaces the whole mask with write data bits [15:0].
- R3: A read is registered: the cycle after `bus_rd` is high, `bus_rdata` holds the status or mask value zero-extended to 32 bits, or zero for any other address.
- R4: `irq_pending` equals the OR of (status AND mask) and takes its new value at the same clock edge as the register that changed it.
- R5: A set pulse on a source line wins over an acknowledge write that clears the same bit in the same cycle, so the bit ends up set.
- R6: After a mask write, `unmask_evt` is high for exactly one cycle if the status after that edge ANDed with the new mask is nonzero, and it stays low otherwise.
- R7: Writes to any other address, and write data bits [31:16], have no effect on status or mask.
- R8: Synchronous active-high reset clears status, mask, `irq_pending`, `unmask_evt` and `bus_rdata`.
- R9: Source line i sets only status bit i, and a set bit stays latched until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_set | input | 16 | One-cycle set pulses, one per source (bit 3: DMA) |
| bus_addr | input | 12 | Byte address within the I/O window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, low 16 bits used |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_pending | output | 1 | Any enabled request latched |
| unmask_evt | output | 1 | One-cycle pulse when a mask load exposes a latched request |

## Verification
The hardest case to reach is a set pulse and a clearing acknowledge that land on the same bit in the same cycle. The stimulus drives both in one cycle. The bench then reads status back and checks that the bit survived while the acknowledge still cleared the other bits. The unmask event is reached by latching a request while its mask bit is off and then loading a mask that enables it. A later mask load that enables nothing latched must leave the pulse low.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_MASK = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode #(
  parameter int ADDR_W   = 12,
  parameter int STAT_OFS = 'h070,
  parameter int MASK_OFS = 'h074
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output irqc_pkg::reg_sel_e sel,
  output logic              wr_stat,
  output logic              wr_mask
);
  localparam int WA_W = ADDR_W - 2;
  localparam logic [WA_W-1:0] STAT_WA = WA_W'(STAT_OFS >> 2);
  localparam logic [WA_W-1:0] MASK_WA = WA_W'(MASK_OFS >> 2);

  logic [WA_W-1:0] waddr;
  logic [1:0]      unused_lsb;

  assign waddr      = addr[ADDR_W-1:2];
  assign unused_lsb = addr[1:0];

  always_comb begin
    if (waddr == STAT_WA)      sel = irqc_pkg::SEL_STAT;
    else if (waddr == MASK_WA) sel = irqc_pkg::SEL_MASK;
    else                       sel = irqc_pkg::SEL_NONE;
  end

  assign wr_stat = wr && (sel == irqc_pkg::SEL_STAT);
  assign wr_mask = wr && (sel == irqc_pkg::SEL_MASK);
endmodule

// File: rtl/irqc_status.sv
module irqc_status #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         ack_we,
  input  logic [N-1:0] ack_data,
  output logic [N-1:0] status_d,
  output logic [N-1:0] status_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      status_d[i] = status_q[i];
      if (ack_we) status_d[i] = status_q[i] & ack_data[i];
      if (set_i[i]) status_d[i] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst) status_q[i] <= 1'b0;
      else     status_q[i] <= status_d[i];
    end
  end
endmodule

// File: rtl/irqc_mask_eval.sv
module irqc_mask_eval #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mask_we,
  input  logic [N-1:0] mask_data,
  input  logic [N-1:0] status_d,
  output logic [N-1:0] mask_q,
  output logic         pend_q,
  output logic         evt_q
);
  logic [N-1:0] mask_d;

  assign mask_d = mask_we ? mask_data : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      pend_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      pend_q <= |(status_d & mask_d);
      evt_q  <= mask_we && (|(status_d & mask_data));
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int N_SRC    = 16,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int STAT_OFS = 'h070,
  parameter int MASK_OFS = 'h074
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_set,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_pending,
  output logic              unmask_evt
);
  localparam int PAD_W = DATA_W - N_SRC;

  irqc_pkg::reg_sel_e sel;
  logic               wr_stat;
  logic               wr_mask;
  logic [N_SRC-1:0]   wlo;
  logic [N_SRC-1:0]   status_d;
  logic [N_SRC-1:0]   status_q;
  logic [N_SRC-1:0]   mask_q;
  logic [DATA_W-1:0]  rdata_q;
  logic               unused_whi;

  assign wlo        = bus_wdata[N_SRC-1:0];
  assign unused_whi = ^bus_wdata[DATA_W-1:N_SRC];

  irqc_decode #(
    .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)
  ) u_dec (
    .addr(bus_addr), .wr(bus_wr), .sel(sel),
    .wr_stat(wr_stat), .wr_mask(wr_mask)
  );

  irqc_status #(.N(N_SRC)) u_stat (
    .clk(clk), .rst(rst), .set_i(src_set),
    .ack_we(wr_stat), .ack_data(wlo),
    .status_d(status_d), .status_q(status_q)
  );

  irqc_mask_eval #(.N(N_SRC)) u_mask (
    .clk(clk), .rst(rst), .mask_we(wr_mask), .mask_data(wlo),
    .status_d(status_d), .mask_q(mask_q),
    .pend_q(irq_pending), .evt_q(unmask_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (bus_rd) begin
      unique case (sel)
        irqc_pkg::SEL_STAT: rdata_q <= {{PAD_W{1'b0}}, status_q};
        irqc_pkg::SEL_MASK: rdata_q <= {{PAD_W{1'b0}}, mask_q};
        default:            rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] src_set,
  input logic         wr_stat,
  input logic         wr_mask,
  input logic [N-1:0] wlo,
  input logic [N-1:0] status_q,
  input logic [N-1:0] mask_q,
  input logic         irq_pending,
  input logic         unmask_evt
);
  p_ack_and_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && src_set == '0) |=> status_q == ($past(status_q) & $past(wlo)));

  p_mask_load_r2: assert property (@(posedge clk) disable iff (rst)
    wr_mask |=> mask_q == $past(wlo));

  p_pend_match_r4: assert property (@(posedge clk) disable iff (rst)
    irq_pending == (|(status_q & mask_q)));

  p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (src_set != '0) |=> (status_q & $past(src_set)) == $past(src_set));

  p_evt_cause_r6: assert property (@(posedge clk) disable iff (rst)
    unmask_evt |-> ($past(wr_mask) && (|(status_q & mask_q))));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!wr_stat && src_set == '0) |=> $stable(status_q));

  p_mask_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !wr_mask |=> $stable(mask_q));

  p_reset_r8: assert property (@(posedge clk)
    rst |=> (status_q == '0 && mask_q == '0 && !irq_pending && !unmask_evt));
endmodule

bind irqc_top irqc_checker #(.N(N_SRC)) u_chk (
  .clk(clk), .rst(rst), .src_set(src_set), .wr_stat(wr_stat),
  .wr_mask(wr_mask), .wlo(wlo), .status_q(status_q), .mask_q(mask_q),
  .irq_pending(irq_pending), .unmask_evt(unmask_evt)
);

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_STAT = 12'h070;
  localparam logic [11:0] A_MASK = 12'h074;
  localparam logic [11:0] A_OTHER = 12'h078;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] src_set = '0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_pending;
  logic        unmask_evt;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqc_top dut (
    .clk(clk), .rst(rst), .src_set(src_set), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq_pending(irq_pending), .unmask_evt(unmask_evt)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one bus/source cycle; returns at the negedge after the capturing edge
  task automatic cyc(input logic wr, input logic [11:0] a, input logic [31:0] d,
                     input logic [15:0] s);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; src_set = s;
    @(negedge clk);
    bus_wr = 1'b0; src_set = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R8 pending", {31'b0, irq_pending}, 0);
    chk("R8 evt", {31'b0, unmask_evt}, 0);
    chk("R8 rdata", bus_rdata, 0);
    rd(A_STAT, v); chk("R8 status", v, 0);
    rd(A_MASK, v); chk("R8 mask", v, 0);
  endtask

  task automatic t_sources;
    logic [31:0] v;
    cyc(1'b0, A_OTHER, 0, 16'h0009);
    chk("R4 masked pending low", {31'b0, irq_pending}, 0);
    rd(A_STAT, v); chk("R9 R3 latched bits", v, 32'h0000_0009);
    rd(A_STAT, v); chk("R9 still latched", v, 32'h0000_0009);
  endtask

  task automatic t_unmask;
    logic [31:0] v;
    cyc(1'b1, A_MASK, 32'h0000_0008, 0);
    chk("R6 evt pulse", {31'b0, unmask_evt}, 1);
    chk("R4 pending on mask", {31'b0, irq_pending}, 1);
    @(negedge clk);
    chk("R6 evt one cycle", {31'b0, unmask_evt}, 0);
    rd(A_MASK, v); chk("R2 mask value", v, 32'h0000_0008);
    cyc(1'b1, A_MASK, 32'hFFFF_0004, 0);
    chk("R6 no evt without overlap", {31'b0, unmask_evt}, 0);
    chk("R4 pending dropped", {31'b0, irq_pending}, 0);
    rd(A_MASK, v); chk("R2 R7 mask replaced", v, 32'h0000_0004);
  endtask

  task automatic t_ack;
    logic [31:0] v;
    cyc(1'b1, A_STAT, 32'h0000_FFFE, 0);
    rd(A_STAT, v); chk("R1 clear bit0", v, 32'h0000_0008);
    cyc(1'b1, A_STAT, 32'hFFFF_FFFF, 0);
    rd(A_STAT, v); chk("R1 ones keep", v, 32'h0000_0008);
    cyc(1'b1, A_STAT | 12'h003, 32'hFFFF_0000, 0);
    rd(A_STAT, v); chk("R1 R7 low half zero clears", v, 0);
  endtask

  task automatic t_priority;
    logic [31:0] v;
    cyc(1'b0, A_OTHER, 0, 16'h0041);
    cyc(1'b1, A_STAT, 32'h0000_0000, 16'h0020);
    rd(A_STAT, v); chk("R5 set beats ack", v, 32'h0000_0020);
  endtask

  task automatic t_pend_ack;
    logic [31:0] v;
    cyc(1'b1, A_MASK, 32'h0000_0020, 0);
    chk("R6 evt on exposed bit5", {31'b0, unmask_evt}, 1);
    chk("R4 pending high", {31'b0, irq_pending}, 1);
    cyc(1'b1, A_STAT, 32'h0000_FFDF, 0);
    chk("R4 pending low after ack", {31'b0, irq_pending}, 0);
    cyc(1'b0, A_OTHER, 0, 16'h0020);
    chk("R4 pending from source", {31'b0, irq_pending}, 1);
  endtask

  task automatic t_other;
    logic [31:0] v;
    cyc(1'b1, A_OTHER, 32'h0000_0000, 0);
    cyc(1'b1, 12'h06C, 32'h0000_0000, 0);
    rd(A_STAT, v); chk("R7 status untouched", v, 32'h0000_0020);
    rd(A_MASK, v); chk("R7 mask untouched", v, 32'h0000_0020);
    rd(A_OTHER, v); chk("R3 unmapped read zero", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_sources();
    t_unmask();
    t_ack();
    t_priority();
    t_pend_ack();
    t_other();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule